// File: doc/BRIEF.md
# Sparse Daisy-Chained Channel Readout

This block is the digital output stage of a 128-channel front-end chip. Each channel's discriminator flags a hit. On a readout request, the block freezes the set of flagged channels. It then waits until it holds the chain token. After that it sends one 32-bit record per flagged channel, in ascending channel order, over a 4-bit bus. Channels without a hit take no bus time.

The amplitude converter and the peak-time store are shared by all channels. The block drives the channel index it wants to read and samples the returned amplitude and peak time when it loads that channel's record.

Several chips share one bus in a daisy chain. While a chip is not sending, it forwards the data arriving from the chip behind it unchanged. When it has sent its last record, or at once if it has nothing to send, it pulses its token output so the next chip can begin. Hits that arrive while a readout is in progress are held for the following readout.

Top module: `sparse_chain_readout`

## Requirements
- R1: A start pulse accepted in idle freezes the pending hit set: all hits seen since the previous accepted start, plus any hit in the start cycle. Only those channels are read out, each once. Hits arriving after that cycle are sent in the next readout.
- R2: Within one readout, records leave in ascending channel-index order.
- R3: Record layout: bits 31:25 hold the channel index, bits 24:12 the peak time, and bits 11:0 the amplitude.
- R4: Each record takes 8 consecutive cycles with vld_o high, most significant nibble first. Consecutive records follow with no idle cycle, so a readout of n hits keeps vld_o high for exactly 8n cycles.
- R5: After a start, nothing is sent until token_i is seen high. A token_i seen while idle has no effect: token_o, vld_o and busy_o stay low.
- R6: token_o is high for exactly one cycle. With n hits, counting the cycle after the edge that accepted token_i as cycle 1, token_o is high in cycle 8n+1. For n = 0 this is cycle 1.
- R7: Whenever the block is not sending, nib_o and vld_o equal chain_nib_i and chain_vld_i.
- R8: A start pulse that arrives while a readout is in progress is ignored. busy_o is high from the cycle after an accepted start through the token_o cycle, and low afterwards.
- R9: ch_sel_o shows the channel about to be loaded. amp_i and ptime_i are sampled on the same clock edge that loads that channel's record.
- R10: After reset, vld_o, token_o and busy_o are low, and no hit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 128 | Per-channel hit pulses from the discriminators |
| start_i | input | 1 | Readout request |
| ch_sel_o | output | 7 | Channel index presented to the shared converter |
| amp_i | input | 12 | Amplitude of the selected channel |
| ptime_i | input | 13 | Peak time of the selected channel |
| token_i | input | 1 | Chain token from the previous chip |
| token_o | output | 1 | One-cycle token pulse to the next chip |
| chain_nib_i | input | 4 | Nibble from the downstream chip |
| chain_vld_i | input | 1 | Valid flag from the downstream chip |
| nib_o | output | 4 | Bus nibble |
| vld_o | output | 1 | Bus valid |
| busy_o | output | 1 | Readout in progress |

## Verification
On every cycle, the assertions check the following:
- token_o never stays high for two cycles.
- A record, once started, is not cut short.
- The block keeps waiting while no token has arrived.
- The channel chosen by the encoder is really pending.
- A pending flag is only cleared while something is pending.

Only the scenarios can show the rest:
- the ascending order and field packing of the records;
- the exact cycle at which the token is passed on;
- deferral of hits that arrive mid-readout to the next readout;
- that start and token inputs are ignored in the wrong state.

// File: rtl/readout_pkg.sv
package readout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND,
    ST_DONE
  } rd_state_e;
endpackage

// File: rtl/pri_enc.sv
module pri_enc #(
  parameter int N = 128,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/hit_tracker.sv
module hit_tracker #(
  parameter int N = 128,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     hit_i,
  input  logic             latch_i,
  input  logic             take_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] arm_q, scan_q, take_mask;

  generate
    for (genvar g = 0; g < N; g++) begin : g_mask
      assign take_mask[g] = take_i && (idx_o == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= '0;
      scan_q <= '0;
    end else if (latch_i) begin
      arm_q  <= '0;
      scan_q <= arm_q | hit_i;
    end else begin
      arm_q  <= arm_q | hit_i;
      scan_q <= scan_q & ~take_mask;
    end
  end

  pri_enc #(.N(N)) u_enc (
    .req_i(scan_q),
    .any_o(any_o),
    .idx_o(idx_o)
  );

  // R2
  pick_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> scan_q[idx_o]);
  // R1
  take_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> any_o);
endmodule

// File: rtl/nib_shifter.sv
module nib_shifter #(
  parameter int WORD_W = 32,
  parameter int NIB_W = 4,
  localparam int NIBS = WORD_W / NIB_W,
  localparam int CNT_W = $clog2(NIBS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic              last_o
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_q << NIB_W;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign nib_o  = sh_q[WORD_W-1 -: NIB_W];
  assign last_o = (cnt_q == CNT_W'(NIBS - 1));
endmodule

// File: rtl/sparse_chain_readout.sv
module sparse_chain_readout
  import readout_pkg::*;
#(
  parameter int N_CH = 128,
  parameter int AMP_W = 12,
  parameter int WORD_W = 32,
  parameter int NIB_W = 4,
  localparam int IDX_W = $clog2(N_CH),
  localparam int TIME_W = WORD_W - IDX_W - AMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   hit_i,
  input  logic              start_i,
  output logic [IDX_W-1:0]  ch_sel_o,
  input  logic [AMP_W-1:0]  amp_i,
  input  logic [TIME_W-1:0] ptime_i,
  input  logic              token_i,
  output logic              token_o,
  input  logic [NIB_W-1:0]  chain_nib_i,
  input  logic              chain_vld_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic              vld_o,
  output logic              busy_o
);
  rd_state_e st_q, st_d;
  logic any, last, latch, take, sending;
  logic [IDX_W-1:0]  idx;
  logic [NIB_W-1:0]  own_nib;
  logic [WORD_W-1:0] rec;

  assign latch = (st_q == ST_IDLE) && start_i;
  assign take  = any && (((st_q == ST_WAIT) && token_i) || ((st_q == ST_SEND) && last));

  hit_tracker #(.N(N_CH)) u_hits (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_i),
    .latch_i(latch),
    .take_i (take),
    .any_o  (any),
    .idx_o  (idx)
  );

  assign rec = {idx, ptime_i, amp_i};

  nib_shifter #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(take),
    .word_i(rec),
    .nib_o (own_nib),
    .last_o(last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_WAIT;
      ST_WAIT: if (token_i) st_d = any ? ST_SEND : ST_DONE;
      ST_SEND: if (last && !any) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign sending  = (st_q == ST_SEND);
  assign ch_sel_o = idx;
  assign nib_o    = sending ? own_nib : chain_nib_i;
  assign vld_o    = sending | chain_vld_i;
  assign token_o  = (st_q == ST_DONE);
  assign busy_o   = (st_q != ST_IDLE);

  // R6
  token_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |=> !token_o);
  // R4
  record_whole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sending && !last) |=> sending);
  // R5
  hold_for_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_WAIT) && !token_i) |=> (st_q == ST_WAIT) && !vld_o == !chain_vld_i);
endmodule

// File: tb/tb_sparse_chain_readout.sv
`timescale 1ns/1ps
module tb_sparse_chain_readout;
  localparam int N_CH = 128;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [N_CH-1:0] hit_i = '0;
  logic start_i = 1'b0, token_i = 1'b0;
  logic [6:0] ch_sel_o;
  logic [11:0] amp_i;
  logic [12:0] ptime_i;
  logic token_o, vld_o, busy_o;
  logic [3:0] chain_nib_i = '0, nib_o;
  logic chain_vld_i = 1'b0;

  sparse_chain_readout dut (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit_i), .start_i(start_i),
    .ch_sel_o(ch_sel_o), .amp_i(amp_i), .ptime_i(ptime_i),
    .token_i(token_i), .token_o(token_o), .chain_nib_i(chain_nib_i),
    .chain_vld_i(chain_vld_i), .nib_o(nib_o), .vld_o(vld_o), .busy_o(busy_o)
  );

  // shared converter model
  always_comb begin
    amp_i   = 12'(int'(ch_sel_o) * 37 + 5);
    ptime_i = 13'(int'(ch_sel_o) * 101 + 3);
  end

  int errors = 0, checks = 0;
  logic [N_CH-1:0] model_arm = '0;
  logic [31:0] exp_q[$];
  logic mon_en = 1'b0;
  int nib_cnt = 0;
  logic [31:0] acc = '0;

  function automatic logic [31:0] exp_word(int c);
    return {7'(c), 13'(c * 101 + 3), 12'(c * 37 + 5)};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: assemble records and compare with scoreboard
  always @(negedge clk) begin
    if (mon_en && vld_o) begin
      acc = {acc[27:0], nib_o};
      nib_cnt++;
      if (nib_cnt == 8) begin
        nib_cnt = 0;
        if (exp_q.size() == 0) check(1'b0, "R1", "unexpected record", acc, '0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(acc == e, "R2/R3/R9", "record", acc, e);
        end
      end
    end
  end

  task automatic hits(input logic [N_CH-1:0] m);
    @(negedge clk);
    hit_i = m;
    model_arm |= m;
    @(negedge clk);
    hit_i = '0;
  endtask

  // driver: push expected records, run one readout, time the token
  task automatic run_readout();
    int n = 0, k = 1, vcnt = 0;
    for (int c = 0; c < N_CH; c++)
      if (model_arm[c]) begin
        exp_q.push_back(exp_word(c));
        n++;
      end
    model_arm = '0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o == 1'b1, "R8", "busy after start", 32'(busy_o), 1);
    repeat (2) begin
      @(negedge clk);
      check(vld_o == 1'b0 && token_o == 1'b0, "R5", "silent before token", 32'(vld_o), 0);
    end
    mon_en = 1'b1;
    token_i = 1'b1;
    @(negedge clk);
    token_i = 1'b0;
    while (!token_o && k < 5000) begin
      if (vld_o) vcnt++;
      @(negedge clk);
      k++;
    end
    check(k == 8 * n + 1, "R6", "token_o cycle", 32'(k), 32'(8 * n + 1));
    check(vcnt == 8 * n, "R4", "valid cycles", 32'(vcnt), 32'(8 * n));
    @(negedge clk);
    check(token_o == 1'b0, "R6", "token one cycle", 32'(token_o), 0);
    check(busy_o == 1'b0, "R8", "idle after token", 32'(busy_o), 0);
    mon_en = 1'b0;
    check(exp_q.size() == 0, "R1", "records missing", 32'(exp_q.size()), 0);
    check(nib_cnt == 0, "R4", "partial record", 32'(nib_cnt), 0);
    exp_q.delete();
    nib_cnt = 0;
  endtask

  bit done = 1'b0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(vld_o == 0 && token_o == 0 && busy_o == 0, "R10", "reset outputs",
          {29'd0, vld_o, token_o, busy_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 nothing pending: empty readout
    run_readout();

    // R7 pass-through while idle
    chain_nib_i = 4'hA; chain_vld_i = 1'b1;
    @(negedge clk);
    check(nib_o == 4'hA && vld_o == 1'b1, "R7", "idle pass-through", 32'(nib_o), 32'hA);
    chain_nib_i = 4'h3; chain_vld_i = 1'b0;
    @(negedge clk);
    check(nib_o == 4'h3 && vld_o == 1'b0, "R7", "idle pass-through 2", 32'(nib_o), 32'h3);

    // R5 token in idle ignored
    token_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(token_o == 0 && vld_o == 0 && busy_o == 0, "R5", "token while idle",
            {29'd0, token_o, vld_o, busy_o}, 0);
    end
    token_i = 1'b0;

    // R2 R3 scattered hits, given out of order
    hits((128'd1 << 127) | (128'd1 << 64));
    hits((128'd1 << 3) | 128'd1);
    run_readout();

    // R1 single hit, repeated hit on same channel
    hits(128'd1 << 77);
    hits(128'd1 << 77);
    run_readout();

    // R7 pass-through while waiting for token
    hits(128'd1 << 9);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chain_nib_i = 4'h5; chain_vld_i = 1'b1;
    @(negedge clk);
    check(nib_o == 4'h5 && vld_o == 1'b1 && busy_o == 1'b1, "R7", "wait pass-through",
          32'(nib_o), 32'h5);
    chain_vld_i = 1'b0;
    exp_q.push_back(exp_word(9));
    model_arm = '0;
    mon_en = 1'b1;
    token_i = 1'b1;
    @(negedge clk);
    token_i = 1'b0;
    repeat (9) @(negedge clk);
    mon_en = 1'b0;
    check(exp_q.size() == 0 && busy_o == 0, "R4", "waited record sent", 32'(exp_q.size()), 0);

    // R8 R1 start and hit during readout
    hits((128'd1 << 10) | (128'd1 << 20));
    fork
      run_readout();
      begin
        repeat (7) @(negedge clk);
        start_i = 1'b1;
        hit_i = 128'd1 << 40;
        model_arm[40] = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        hit_i = '0;
      end
    join
    repeat (2) @(negedge clk);
    check(busy_o == 1'b0, "R8", "start during readout ignored", 32'(busy_o), 0);
    run_readout();  // R1 deferred hit on channel 40

    // R4 R2 all channels back to back
    hits('1);
    run_readout();

    done = 1'b1;
    finish_run();
  end
endmodule